// File: doc/BRIEF.md
# Transactional Read/Write Set Conflict Tracker

This block tracks which cache lines a running hardware transaction has touched. Each transactional load or store address is reduced to a line tag and kept in a small fully associative table. Each entry of the table carries a valid bit, the tag, a read mark and a write mark. A second access to a line that is already held updates the marks of its entry and does not allocate another one. The table therefore holds the read set and the write set of the transaction together. Addresses arrive already physical.

Coherence snoops from other agents and local line evictions are compared against every entry in parallel. A remote write that hits any tracked line, or a remote read that hits a written line, raises a sticky conflict abort request. An access that needs a new entry while every entry is in use raises a capacity abort request, and so does the eviction of a written line. The transaction controller reads both requests and pulses a clear when the transaction commits or aborts. That clear empties the table and drops both requests in one cycle.

The block has two special recording rules. While load tracking is suspended, plain loads are not recorded, but stores are still recorded. A lock-elision acquire always enters the lock's line into the read set.

Top module: `rwset_tracker`

## Requirements
- R1: Out of reset both abort outputs are low and the table is empty, so that a remote write to any line raises no conflict.
- R2: Addresses are compared at line granularity. Two addresses that differ only in their low log2(LINE_BYTES) bits name the same line, and addresses in different lines never match.
- R3: A remote write snoop (snp_write_i=1) that hits a line marked read or written sets abort_conflict_o on the following clock edge.
- R4: A remote read snoop (snp_write_i=0) sets abort_conflict_o on the following edge when the line is marked written. It has no effect on a line that is only marked read.
- R5: An eviction of a line marked written sets abort_capacity_o on the following edge. An eviction of a read-only line or of an untracked line has no effect.
- R6: A recorded access to a line that is not held, made while all DEPTH entries are valid, sets abort_capacity_o and leaves abort_conflict_o low. The line is not entered. An access to a line that is already held never consumes an entry.
- R7: An access with acc_lock_i=1 (lock-elision acquire) marks its line read, even while load tracking is suspended. It marks the line written as well when acc_write_i=1.
- R8: While ld_suspend_i=1, a load (acc_write_i=0, acc_lock_i=0) is not recorded. A store is still recorded and marked written.
- R9: clear_i empties the table and drops both abort outputs on the next edge. An access presented in the same cycle as clear_i is discarded.
- R10: Once set, each abort output stays high until clear_i.
- R11: Accesses presented while tx_active_i=0 are not recorded.
- R12: A snoop is compared against the table as it stands before the edge. An access to the same line in the same cycle is not seen by that snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_active_i | input | 1 | A transaction is in flight; accesses are recorded only while high |
| ld_suspend_i | input | 1 | Load tracking suspended |
| acc_valid_i | input | 1 | Transactional access present |
| acc_addr_i | input | ADDR_W | Physical address of the access |
| acc_write_i | input | 1 | Access is a store |
| acc_lock_i | input | 1 | Access is a lock-elision acquire |
| snp_valid_i | input | 1 | Coherence snoop from another agent present |
| snp_addr_i | input | ADDR_W | Physical address of the snoop |
| snp_write_i | input | 1 | Snoop is a remote write (1) or remote read (0) |
| evict_valid_i | input | 1 | Local line eviction present |
| evict_addr_i | input | ADDR_W | Physical address of the evicted line |
| clear_i | input | 1 | Commit or abort: empty the table and drop the requests |
| abort_conflict_o | output | 1 | Sticky conflict abort request |
| abort_capacity_o | output | 1 | Sticky capacity abort request |

## Verification
The situation that is hardest to reach from the ports is a full table meeting one more new line. Reaching it takes exactly DEPTH distinct recorded lines, and a repeated line must not count toward that number. The bench uses a four-entry configuration. It fills the table with one to DEPTH+1 distinct lines, re-touches held lines and then probes the last line with a remote write, so it sees both the capacity request and the missing entry. A second sweep crosses every access flavour (active or not, suspended or not, lock or not, load or store) with every probe kind, at both ends of the line and one line beyond. The expected marks are computed from the flavour's bits.

// File: rtl/rwset_pkg.sv
package rwset_pkg;

  typedef struct packed {
    logic rec;
    logic set_r;
    logic set_w;
  } acc_mark_t;

  // decide whether an access is recorded and which marks it sets
  function automatic acc_mark_t decode_access(input logic valid, input logic active,
                                              input logic write, input logic lock,
                                              input logic suspend);
    acc_mark_t m;
    m.rec   = valid & active & (write | lock | ~suspend);
    m.set_r = lock | ~write;
    m.set_w = write;
    return m;
  endfunction

endpackage

// File: rtl/rwset_entry.sv
module rwset_entry #(
  parameter int TAG_W = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             alloc_i,
  input  logic             upd_i,
  input  logic             set_r_i,
  input  logic             set_w_i,
  input  logic [TAG_W-1:0] acc_tag_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic [TAG_W-1:0] evict_tag_i,
  output logic             valid_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             acc_hit_o,
  output logic             snp_hit_o,
  output logic             evict_hit_o
);

  logic             valid_q, rd_q, wr_q;
  logic [TAG_W-1:0] tag_q;

  assign acc_hit_o   = valid_q && (tag_q == acc_tag_i);
  assign snp_hit_o   = valid_q && (tag_q == snp_tag_i);
  assign evict_hit_o = valid_q && (tag_q == evict_tag_i);
  assign valid_o     = valid_q;
  assign rd_o        = rd_q;
  assign wr_o        = wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      tag_q   <= '0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      tag_q   <= acc_tag_i;
      rd_q    <= set_r_i;
      wr_q    <= set_w_i;
    end else if (upd_i && acc_hit_o) begin
      rd_q <= rd_q | set_r_i;
      wr_q <= wr_q | set_w_i;
    end
  end

endmodule

// File: rtl/rwset_pick_free.sv
module rwset_pick_free #(
  parameter int DEPTH = 16
) (
  input  logic [DEPTH-1:0] busy_i,
  output logic [DEPTH-1:0] grant_o,
  output logic             any_free_o
);

  always_comb begin
    grant_o    = '0;
    any_free_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!busy_i[i] && !any_free_o) begin
        grant_o[i] = 1'b1;
        any_free_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/rwset_tracker.sv
module rwset_tracker #(
  parameter int ADDR_W     = 40,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_active_i,
  input  logic              ld_suspend_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              acc_lock_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              snp_write_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  input  logic              clear_i,
  output logic              abort_conflict_o,
  output logic              abort_capacity_o
);
  import rwset_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0] acc_tag, snp_tag, evict_tag;
  logic             unused_off;
  acc_mark_t        mark;

  logic [DEPTH-1:0] valid_vec, rd_vec, wr_vec;
  logic [DEPTH-1:0] acc_hit_vec, snp_hit_vec, evict_hit_vec;
  logic [DEPTH-1:0] grant_vec, alloc_vec;
  logic             any_free, any_acc_hit;
  logic             conflict_req, capacity_req, evict_req;
  logic             conflict_q, capacity_q;

  assign acc_tag    = acc_addr_i[ADDR_W-1:OFF_W];
  assign snp_tag    = snp_addr_i[ADDR_W-1:OFF_W];
  assign evict_tag  = evict_addr_i[ADDR_W-1:OFF_W];
  assign unused_off = ^{acc_addr_i[OFF_W-1:0], snp_addr_i[OFF_W-1:0], evict_addr_i[OFF_W-1:0]};

  assign mark = decode_access(acc_valid_i, tx_active_i, acc_write_i, acc_lock_i, ld_suspend_i);

  rwset_pick_free #(.DEPTH(DEPTH)) u_pick (
    .busy_i     (valid_vec),
    .grant_o    (grant_vec),
    .any_free_o (any_free)
  );

  assign any_acc_hit = |acc_hit_vec;
  assign alloc_vec   = (mark.rec && !any_acc_hit) ? grant_vec : '0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    rwset_entry #(.TAG_W(TAG_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (clear_i),
      .alloc_i     (alloc_vec[g]),
      .upd_i       (mark.rec),
      .set_r_i     (mark.set_r),
      .set_w_i     (mark.set_w),
      .acc_tag_i   (acc_tag),
      .snp_tag_i   (snp_tag),
      .evict_tag_i (evict_tag),
      .valid_o     (valid_vec[g]),
      .rd_o        (rd_vec[g]),
      .wr_o        (wr_vec[g]),
      .acc_hit_o   (acc_hit_vec[g]),
      .snp_hit_o   (snp_hit_vec[g]),
      .evict_hit_o (evict_hit_vec[g])
    );
  end

  // remote read conflicts only with written lines, remote write with any tracked line
  assign conflict_req = snp_valid_i &&
                        |(snp_hit_vec & (wr_vec | (rd_vec & {DEPTH{snp_write_i}})));
  assign evict_req    = evict_valid_i && |(evict_hit_vec & wr_vec);
  assign capacity_req = (mark.rec && !any_acc_hit && !any_free) || evict_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conflict_q <= 1'b0;
      capacity_q <= 1'b0;
    end else if (clear_i) begin
      conflict_q <= 1'b0;
      capacity_q <= 1'b0;
    end else begin
      conflict_q <= conflict_q | conflict_req;
      capacity_q <= capacity_q | capacity_req;
    end
  end

  assign abort_conflict_o = conflict_q;
  assign abort_capacity_o = capacity_q;

endmodule

// File: rtl/rwset_tracker_chk.sv
module rwset_tracker_chk #(
  parameter int DEPTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             acc_valid_i,
  input logic             snp_valid_i,
  input logic             evict_valid_i,
  input logic             abort_conflict_o,
  input logic             abort_capacity_o,
  input logic [DEPTH-1:0] valid_vec,
  input logic [DEPTH-1:0] alloc_vec
);

  assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (valid_vec == '0) && !abort_conflict_o && !abort_capacity_o);

  assert_conflict_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_conflict_o && !clear_i) |=> abort_conflict_o);

  assert_capacity_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_capacity_o && !clear_i) |=> abort_capacity_o);

  assert_conflict_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_conflict_o) |-> $past(snp_valid_i));

  assert_capacity_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_capacity_o) |-> $past(acc_valid_i || evict_valid_i));

  assert_single_alloc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(alloc_vec));

  assert_no_shrink_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> $countones(valid_vec) >= $past($countones(valid_vec)));

endmodule

bind rwset_tracker rwset_tracker_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .clear_i          (clear_i),
  .acc_valid_i      (acc_valid_i),
  .snp_valid_i      (snp_valid_i),
  .evict_valid_i    (evict_valid_i),
  .abort_conflict_o (abort_conflict_o),
  .abort_capacity_o (abort_capacity_o),
  .valid_vec        (valid_vec),
  .alloc_vec        (alloc_vec)
);

// File: tb/rwset_tracker_bench.sv
module rwset_tracker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int LINE_BYTES = 16;
  localparam int DEPTH      = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tx_active_i = 1'b0, ld_suspend_i = 1'b0;
  logic              acc_valid_i = 1'b0, acc_write_i = 1'b0, acc_lock_i = 1'b0;
  logic [ADDR_W-1:0] acc_addr_i = '0, snp_addr_i = '0, evict_addr_i = '0;
  logic              snp_valid_i = 1'b0, snp_write_i = 1'b0, evict_valid_i = 1'b0;
  logic              clear_i = 1'b0;
  logic              abort_conflict_o, abort_capacity_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rwset_tracker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .DEPTH(DEPTH)) u_rwset_tracker (
    .clk_i, .rst_ni, .tx_active_i, .ld_suspend_i, .acc_valid_i, .acc_addr_i,
    .acc_write_i, .acc_lock_i, .snp_valid_i, .snp_addr_i, .snp_write_i,
    .evict_valid_i, .evict_addr_i, .clear_i, .abort_conflict_o, .abort_capacity_o
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic do_access(input int addr, input logic wr, input logic lock,
                           input logic susp, input logic act);
    acc_valid_i = 1'b1; acc_addr_i = ADDR_W'(addr); acc_write_i = wr;
    acc_lock_i = lock; ld_suspend_i = susp; tx_active_i = act;
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_write_i = 1'b0; acc_lock_i = 1'b0;
    ld_suspend_i = 1'b0; tx_active_i = 1'b1;
  endtask

  task automatic do_snoop(input int addr, input logic wr);
    snp_valid_i = 1'b1; snp_addr_i = ADDR_W'(addr); snp_write_i = wr;
    @(negedge clk_i);
    snp_valid_i = 1'b0; snp_write_i = 1'b0;
  endtask

  task automatic do_evict(input int addr);
    evict_valid_i = 1'b1; evict_addr_i = ADDR_W'(addr);
    @(negedge clk_i);
    evict_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tx_active_i = 1'b1;
    @(negedge clk_i);

    // R1: reset state
    check("R1 conflict", abort_conflict_o, 1'b0);
    check("R1 capacity", abort_capacity_o, 1'b0);
    do_snoop(16'h40, 1'b1);
    check("R1 empty table", abort_conflict_o, 1'b0);

    // flavour x probe x offset sweep (R2 R3 R4 R5 R7 R8 R11)
    for (int kind = 0; kind < 8; kind++) begin
      for (int p = 0; p < 3; p++) begin
        for (int o = 0; o < 3; o++) begin
          logic act, susp, lock, wr, exp_r, exp_w, hit, exp_c, exp_k;
          int base, paddr;
          act   = (kind < 6);
          susp  = (kind >= 3 && kind <= 5);
          lock  = (kind == 2 || kind == 5);
          wr    = (kind == 1 || kind == 4 || kind == 7);
          exp_r = act && (lock || (!wr && !susp));
          exp_w = act && wr;
          base  = (kind * 3 + 1) * LINE_BYTES;
          hit   = (o < 2);
          paddr = base + ((o == 0) ? 0 : (o == 1) ? LINE_BYTES - 1 : LINE_BYTES);
          exp_c = (p == 0) ? (hit && exp_w) : (p == 1) ? (hit && (exp_r || exp_w)) : 1'b0;
          exp_k = (p == 2) && hit && exp_w;
          do_clear();
          do_access(base, wr, lock, susp, act);
          if (p == 2) do_evict(paddr);
          else        do_snoop(paddr, p == 1);
          check($sformatf("R2/R3/R4/R5/R7/R8/R11 conflict k%0d p%0d o%0d", kind, p, o),
                abort_conflict_o, exp_c);
          check($sformatf("R2/R3/R4/R5/R7/R8/R11 capacity k%0d p%0d o%0d", kind, p, o),
                abort_capacity_o, exp_k);
        end
      end
    end

    // R6: fill sweep with repeated lines
    for (int n = 1; n <= DEPTH + 1; n++) begin
      do_clear();
      for (int i = 0; i < n; i++) begin
        do_access((i + 2) * LINE_BYTES, 1'b1, 1'b0, 1'b0, 1'b1);
        do_access(2 * LINE_BYTES + 5, 1'b0, 1'b0, 1'b0, 1'b1);
      end
      check($sformatf("R6 capacity n%0d", n), abort_capacity_o, n > DEPTH);
      check($sformatf("R6 no conflict n%0d", n), abort_conflict_o, 1'b0);
      do_snoop((n + 1) * LINE_BYTES, 1'b1);
      check($sformatf("R6 last line held n%0d", n), abort_conflict_o, n <= DEPTH);
    end

    // R10 sticky, then R9 clear
    do_clear();
    do_access(8 * LINE_BYTES, 1'b0, 1'b0, 1'b0, 1'b1);
    do_snoop(8 * LINE_BYTES, 1'b1);
    repeat (3) @(negedge clk_i);
    check("R10 conflict held", abort_conflict_o, 1'b1);
    do_access(9 * LINE_BYTES, 1'b1, 1'b0, 1'b0, 1'b1);
    do_evict(9 * LINE_BYTES);
    repeat (2) @(negedge clk_i);
    check("R10 capacity held", abort_capacity_o, 1'b1);
    do_clear();
    check("R9 conflict cleared", abort_conflict_o, 1'b0);
    check("R9 capacity cleared", abort_capacity_o, 1'b0);
    do_snoop(8 * LINE_BYTES, 1'b1);
    check("R9 table emptied", abort_conflict_o, 1'b0);

    // R9: access in the same cycle as clear is dropped
    do_clear();
    clear_i = 1'b1;
    do_access(10 * LINE_BYTES, 1'b1, 1'b0, 1'b0, 1'b1);
    clear_i = 1'b0;
    do_snoop(10 * LINE_BYTES, 1'b0);
    check("R9 access with clear dropped", abort_conflict_o, 1'b0);

    // R12: same-cycle snoop does not see the access
    do_clear();
    snp_valid_i = 1'b1; snp_addr_i = ADDR_W'(11 * LINE_BYTES); snp_write_i = 1'b1;
    do_access(11 * LINE_BYTES, 1'b0, 1'b0, 1'b0, 1'b1);
    snp_valid_i = 1'b0; snp_write_i = 1'b0;
    check("R12 same-cycle snoop", abort_conflict_o, 1'b0);
    do_snoop(11 * LINE_BYTES, 1'b1);
    check("R12 later snoop", abort_conflict_o, 1'b1);

    finish_run();
  end

endmodule